// File: doc/BRIEF.md
# Interrupt Controller Setup Sequencer and Command Port

This block is the programming front end of an eight-line priority interrupt controller. Software reaches it through a byte-wide port with one address bit. Writes to the even address carry three kinds of words, told apart by bits 4 and 3: a start word that begins the setup sequence, a control word, and an end-of-service or rotation command. Writes to the odd address carry the line mask in normal operation. During setup the same address carries the follow-on setup words, whose number depends on flags taken from the start word.

The block keeps the setup sequence state and the configuration it gathers: vector base, single-controller flag, four-word flag, nested mode and automatic end-of-service. It also keeps the run-time flags: read select, special mask, armed poll and rotate-on-auto-end. The priority logic lives outside the block. It supplies the pending and in-service registers and its chosen line, and it takes back the one-hot clear from a poll read, the decoded end-of-service command, and the vector formed from the base and the line.

Top module: `pic_ctrl_port`

## Requirements
- R1: After reset the sequence state is 0 and the mask, vector base and every flag are 0.
- R2: A write to address 0 with bit 4 set raises `init_pulse_o` in the same cycle. It clears the mask, vector base, nested, auto-end, read-select, special-mask, poll and rotate flags. It latches the four-word flag from bit 0 and the single flag from bit 1, and it moves the sequence to state 1.
- R3: In state 1 a write to address 1 loads the vector base from bits 7:3. It then moves to state 3 if single and four-word are both set, to state 0 if only single is set, and to state 2 if single is clear.
- R4: In state 2 a write to address 1 moves to state 3 if the four-word flag is set and to state 0 if it is clear.
- R5: In state 3 a write to address 1 sets nested mode from bit 4 and auto-end from bit 1, then returns to state 0.
- R6: The mask is loaded from a write to address 1 only in state 0. No other write changes it except a start word, which clears it.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 arms poll. Bit 0 loads read-select only when bit 1 is set. Bit 5 loads special-mask only when bit 6 is set. A flag that is not loaded keeps its value.
- R8: A write to address 0 with bits 4 and 3 clear raises `cmd_stb_o` in that cycle, with the opcode from bits 7:5 on `cmd_op_o` and the line from bits 2:0 on `cmd_lvl_o`. Opcode 0 clears the rotate flag and opcode 4 sets it. Other opcodes leave it unchanged.
- R9: With poll not armed, a read at address 0 returns the in-service register if read-select is 1 and the pending register if it is 0. A read at address 1 returns the mask.
- R10: With poll armed, a read at either address returns the chosen line index and sets that line's bit in `poll_clr_o`. If no line is chosen, it returns 7 with `poll_clr_o` at 0. Poll is disarmed after the read.
- R11: `vector_o` equals the vector base times 8 plus the chosen line, or plus 7 when no line is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Port address bit |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| pend_i | input | 8 | Pending register from priority logic |
| insvc_i | input | 8 | In-service register from priority logic |
| poll_valid_i | input | 1 | Priority logic has a line to serve |
| poll_line_i | input | 3 | Line chosen by priority logic |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high |
| poll_clr_o | output | 8 | One-hot clear of pending and in-service bits on a poll read |
| init_pulse_o | output | 1 | Start word seen: reset priority state, lower interrupt |
| init_state_o | output | 2 | Setup sequence state |
| single_o | output | 1 | Single controller, no cascade word |
| four_word_o | output | 1 | Mode word expected |
| nested_o | output | 1 | Nested mode flag |
| auto_eoi_o | output | 1 | Automatic end-of-service flag |
| vec_base_o | output | 5 | Vector base, upper bits of vector |
| mask_o | output | 8 | Line mask |
| read_sel_o | output | 1 | Address-0 read selects in-service register |
| special_mask_o | output | 1 | Special mask flag |
| poll_armed_o | output | 1 | Next read is a poll |
| rotate_aeoi_o | output | 1 | Rotate on automatic end-of-service |
| cmd_stb_o | output | 1 | End-of-service or rotation command strobe |
| cmd_op_o | output | 3 | Command opcode |
| cmd_lvl_o | output | 3 | Command line field |
| vector_o | output | 8 | Acknowledge vector |

## Verification
The in-module assertions check on every cycle that a start word lands in state 1 with both latched flags, and that the mask moves only on a normal-state data write or a start word. They also check that states 2 and 3 are reached only on the flag paths that allow them, that an armed poll read disarms, and that the poll clear is at most one-hot and only on a poll read. The bench scenarios are needed for the rest. These are the four complete setup paths through the sequence, all 64 control-word encodings with their conditional flag loads, every opcode and line of the command word, the read multiplexer across data patterns, and the arithmetic of the vector and the spurious value 7.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_BASE = 2'd1,
      ST_CASC = 2'd2,
      ST_MODE = 2'd3
   } seq_st_t;

   typedef struct packed {
      logic start;
      logic ctrl;
      logic cmd;
      logic data;
   } wr_kind_t;

   // even-address word field positions (decoded by behaviour)
   localparam int B_START   = 4;
   localparam int B_CTRL    = 3;
   localparam int B_POLL    = 2;
   localparam int B_RS_EN   = 1;
   localparam int B_RS_VAL  = 0;
   localparam int B_SM_EN   = 6;
   localparam int B_SM_VAL  = 5;
   localparam int B_FOUR    = 0;
   localparam int B_SINGLE  = 1;
   localparam int B_NESTED  = 4;
   localparam int B_AEOI    = 1;
   localparam int OP_LSB    = 5;
   localparam int OP_W      = 3;

endpackage

// File: rtl/pic_wr_classify.sv
module pic_wr_classify
   import pic_port_pkg::*;
(
   input  logic     wr_en_i,
   input  logic     addr_i,
   input  logic     start_bit_i,
   input  logic     ctrl_bit_i,
   output wr_kind_t kind_o
);

   always_comb begin
      kind_o       = '0;
      kind_o.data  = wr_en_i &  addr_i;
      kind_o.start = wr_en_i & ~addr_i &  start_bit_i;
      kind_o.ctrl  = wr_en_i & ~addr_i & ~start_bit_i &  ctrl_bit_i;
      kind_o.cmd   = wr_en_i & ~addr_i & ~start_bit_i & ~ctrl_bit_i;
   end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_port_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES  = 8,
   localparam int IDX_W  = $clog2(LINES),
   localparam int BASE_W = DATA_W - IDX_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_t          kind_i,
   input  logic [DATA_W-1:0] wdata_i,
   output seq_st_t           state_o,
   output logic              single_o,
   output logic              four_o,
   output logic              nested_o,
   output logic              aeoi_o,
   output logic [BASE_W-1:0] base_o,
   output logic [LINES-1:0]  mask_o
);

   seq_st_t st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_RUN;
         single_o <= 1'b0;
         four_o   <= 1'b0;
         nested_o <= 1'b0;
         aeoi_o   <= 1'b0;
         base_o   <= '0;
         mask_o   <= '0;
      end else if (kind_i.start) begin
         st_q     <= ST_BASE;
         four_o   <= wdata_i[B_FOUR];
         single_o <= wdata_i[B_SINGLE];
         nested_o <= 1'b0;
         aeoi_o   <= 1'b0;
         base_o   <= '0;
         mask_o   <= '0;
      end else if (kind_i.data) begin
         unique case (st_q)
            ST_RUN:  mask_o <= wdata_i[LINES-1:0];
            ST_BASE: begin
               base_o <= wdata_i[DATA_W-1:IDX_W];
               if (!single_o)   st_q <= ST_CASC;
               else if (four_o) st_q <= ST_MODE;
               else             st_q <= ST_RUN;
            end
            ST_CASC: st_q <= four_o ? ST_MODE : ST_RUN;
            ST_MODE: begin
               nested_o <= wdata_i[B_NESTED];
               aeoi_o   <= wdata_i[B_AEOI];
               st_q     <= ST_RUN;
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign state_o = st_q;

   p_start_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kind_i.start |=> (st_q == ST_BASE) && (four_o == $past(wdata_i[B_FOUR]))
                       && (single_o == $past(wdata_i[B_SINGLE])))
      else $error("start word did not enter state 1");

   p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i.data && st_q == ST_RUN) |=> mask_o == $past(wdata_i[LINES-1:0]))
      else $error("mask not loaded in state 0");

   p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!kind_i.start && !(kind_i.data && st_q == ST_RUN)) |=> $stable(mask_o))
      else $error("mask changed outside a state-0 data write");

   p_casc_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CASC) |-> !single_o)
      else $error("cascade state reached in single mode");

   p_mode_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MODE) |-> four_o)
      else $error("mode state reached without four-word flag");

   p_mode_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i.data && st_q == ST_MODE) |=> (st_q == ST_RUN)
         && (nested_o == $past(wdata_i[B_NESTED])) && (aeoi_o == $past(wdata_i[B_AEOI])))
      else $error("mode word handling wrong");

endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
   import pic_port_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES  = 8,
   localparam int IDX_W = $clog2(LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  wr_kind_t          kind_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_en_i,
   output logic              read_sel_o,
   output logic              smask_o,
   output logic              poll_o,
   output logic              rot_o,
   output logic              cmd_stb_o,
   output logic [OP_W-1:0]   cmd_op_o,
   output logic [IDX_W-1:0]  cmd_lvl_o
);

   logic [OP_W-1:0] op;
   logic            rot_load;
   logic            unused_bits;

   assign op          = wdata_i[OP_LSB +: OP_W];
   assign rot_load    = kind_i.cmd && (op[OP_W-2:0] == '0);
   assign unused_bits = ^wdata_i[B_START:B_CTRL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         read_sel_o <= 1'b0;
         smask_o    <= 1'b0;
         poll_o     <= 1'b0;
         rot_o      <= 1'b0;
      end else if (kind_i.start) begin
         read_sel_o <= 1'b0;
         smask_o    <= 1'b0;
         poll_o     <= 1'b0;
         rot_o      <= 1'b0;
      end else begin
         if (kind_i.ctrl && wdata_i[B_RS_EN]) read_sel_o <= wdata_i[B_RS_VAL];
         if (kind_i.ctrl && wdata_i[B_SM_EN]) smask_o    <= wdata_i[B_SM_VAL];
         if (kind_i.ctrl && wdata_i[B_POLL])  poll_o     <= 1'b1;
         else if (rd_en_i && poll_o)          poll_o     <= 1'b0;
         if (rot_load)                        rot_o      <= op[OP_W-1];
      end
   end

   assign cmd_stb_o = kind_i.cmd;
   assign cmd_op_o  = op;
   assign cmd_lvl_o = wdata_i[IDX_W-1:0];

   p_poll_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && poll_o && !(kind_i.ctrl && wdata_i[B_POLL])) |=> !poll_o)
      else $error("poll stayed armed after a read");

   p_rs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!kind_i.start && !(kind_i.ctrl && wdata_i[B_RS_EN])) |=> $stable(read_sel_o))
      else $error("read select changed without enable");

   p_rot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!kind_i.start && !rot_load) |=> $stable(rot_o))
      else $error("rotate flag changed without opcode 0 or 4");

endmodule

// File: rtl/pic_read_path.sv
module pic_read_path #(
   parameter int DATA_W = 8,
   parameter int LINES  = 8,
   localparam int IDX_W = $clog2(LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_i,
   input  logic              rd_en_i,
   input  logic              poll_i,
   input  logic              read_sel_i,
   input  logic [LINES-1:0]  pend_i,
   input  logic [LINES-1:0]  insvc_i,
   input  logic [LINES-1:0]  mask_i,
   input  logic              poll_valid_i,
   input  logic [IDX_W-1:0]  poll_line_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [LINES-1:0]  clr_o
);

   localparam logic [IDX_W-1:0] SPUR = IDX_W'(LINES - 1);

   logic poll_rd;
   assign poll_rd = rd_en_i && poll_i;

   always_comb begin
      rdata_o = '0;
      if (poll_rd)
         rdata_o = DATA_W'(poll_valid_i ? poll_line_i : SPUR);
      else if (rd_en_i && addr_i)
         rdata_o = DATA_W'(mask_i);
      else if (rd_en_i)
         rdata_o = DATA_W'(read_sel_i ? insvc_i : pend_i);
   end

   for (genvar g = 0; g < LINES; g++) begin : g_clr
      assign clr_o[g] = poll_rd && poll_valid_i && (poll_line_i == IDX_W'(g));
   end

   p_clr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o))
      else $error("poll clear not one-hot");

   p_clr_only_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_o) |-> (rd_en_i && poll_i && poll_valid_i))
      else $error("poll clear outside a poll read");

endmodule

// File: rtl/pic_ctrl_port.sv
module pic_ctrl_port
   import pic_port_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINES  = 8,
   localparam int IDX_W  = $clog2(LINES),
   localparam int BASE_W = DATA_W - IDX_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [LINES-1:0]  pend_i,
   input  logic [LINES-1:0]  insvc_i,
   input  logic              poll_valid_i,
   input  logic [IDX_W-1:0]  poll_line_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [LINES-1:0]  poll_clr_o,
   output logic              init_pulse_o,
   output logic [1:0]        init_state_o,
   output logic              single_o,
   output logic              four_word_o,
   output logic              nested_o,
   output logic              auto_eoi_o,
   output logic [BASE_W-1:0] vec_base_o,
   output logic [LINES-1:0]  mask_o,
   output logic              read_sel_o,
   output logic              special_mask_o,
   output logic              poll_armed_o,
   output logic              rotate_aeoi_o,
   output logic              cmd_stb_o,
   output logic [OP_W-1:0]   cmd_op_o,
   output logic [IDX_W-1:0]  cmd_lvl_o,
   output logic [DATA_W-1:0] vector_o
);

   localparam logic [IDX_W-1:0] SPUR_LINE = IDX_W'(LINES - 1);

   if (DATA_W < 8) begin : g_chk_width
      $error("DATA_W must hold the 8-bit command fields");
   end
   if (LINES != DATA_W) begin : g_chk_lines
      $error("LINES must equal DATA_W so registers read back whole");
   end
   if ((1 << IDX_W) != LINES) begin : g_chk_pow2
      $error("LINES must be a power of two");
   end

   wr_kind_t kind;
   seq_st_t  st;

   pic_wr_classify u_classify (
      .wr_en_i     (wr_en_i),
      .addr_i      (addr_i),
      .start_bit_i (wdata_i[B_START]),
      .ctrl_bit_i  (wdata_i[B_CTRL]),
      .kind_o      (kind)
   );

   pic_init_seq #(.DATA_W(DATA_W), .LINES(LINES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .wdata_i  (wdata_i),
      .state_o  (st),
      .single_o (single_o),
      .four_o   (four_word_o),
      .nested_o (nested_o),
      .aeoi_o   (auto_eoi_o),
      .base_o   (vec_base_o),
      .mask_o   (mask_o)
   );

   pic_cmd_regs #(.DATA_W(DATA_W), .LINES(LINES)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind_i     (kind),
      .wdata_i    (wdata_i),
      .rd_en_i    (rd_en_i),
      .read_sel_o (read_sel_o),
      .smask_o    (special_mask_o),
      .poll_o     (poll_armed_o),
      .rot_o      (rotate_aeoi_o),
      .cmd_stb_o  (cmd_stb_o),
      .cmd_op_o   (cmd_op_o),
      .cmd_lvl_o  (cmd_lvl_o)
   );

   pic_read_path #(.DATA_W(DATA_W), .LINES(LINES)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_i       (addr_i),
      .rd_en_i      (rd_en_i),
      .poll_i       (poll_armed_o),
      .read_sel_i   (read_sel_o),
      .pend_i       (pend_i),
      .insvc_i      (insvc_i),
      .mask_i       (mask_o),
      .poll_valid_i (poll_valid_i),
      .poll_line_i  (poll_line_i),
      .rdata_o      (rdata_o),
      .clr_o        (poll_clr_o)
   );

   assign init_pulse_o = kind.start;
   assign init_state_o = st;
   assign vector_o     = {vec_base_o, (poll_valid_i ? poll_line_i : SPUR_LINE)};

   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_pulse_o |=> !poll_armed_o && !read_sel_o && !special_mask_o
                       && !rotate_aeoi_o && (mask_o == '0) && (vec_base_o == '0))
      else $error("start word left configuration set");

endmodule

// File: tb/test_pic_ctrl_port.sv
module test_pic_ctrl_port;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, pend = '0, insvc = '0;
   logic       pvalid = 1'b0;
   logic [2:0] pline = '0;

   logic [7:0] rdata, clr, mask, vector;
   logic       init_pulse, single, four, nested, aeoi, rs, sm, poll, rot, stb;
   logic [1:0] state;
   logic [4:0] base;
   logic [2:0] op, lvl;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic       s_pulse, s_stb;
   logic [2:0] s_op, s_lvl;
   logic [7:0] s_rd, s_clr;

   always #(CLK_PERIOD/2) clk = ~clk;

   pic_ctrl_port i_pic_ctrl_port (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .wdata_i(wdata), .pend_i(pend), .insvc_i(insvc), .poll_valid_i(pvalid),
      .poll_line_i(pline), .rdata_o(rdata), .poll_clr_o(clr), .init_pulse_o(init_pulse),
      .init_state_o(state), .single_o(single), .four_word_o(four), .nested_o(nested),
      .auto_eoi_o(aeoi), .vec_base_o(base), .mask_o(mask), .read_sel_o(rs),
      .special_mask_o(sm), .poll_armed_o(poll), .rotate_aeoi_o(rot), .cmd_stb_o(stb),
      .cmd_op_o(op), .cmd_lvl_o(lvl), .vector_o(vector)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      #1;
      s_pulse = init_pulse; s_stb = stb; s_op = op; s_lvl = lvl;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a);
      addr = a; rd_en = 1'b1;
      #1;
      s_rd = rdata; s_clr = clr;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic exp_rs, exp_sm, exp_rot;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 state", state, 0);
      chk("R1 mask", mask, 0);
      chk("R1 base", base, 0);
      chk("R1 flags", {single, four, nested, aeoi, rs, sm, poll, rot}, 0);

      // R2..R6 every setup path
      for (int p = 0; p < 4; p++) begin
         logic s, f;
         logic [1:0] exp_st;
         s = p[1]; f = p[0];
         wr(1'b1, 8'hA5);
         chk("R6 mask load", mask, 8'hA5);
         wr(1'b0, 8'h6B);              // rs=1 sm=1
         wr(1'b0, 8'h80);              // opcode 4, rotate on
         chk("R7 pre rs/sm", {rs, sm}, 2'b11);
         wr(1'b0, {3'b101, 1'b1, 2'b00, s, f});
         chk("R2 pulse", s_pulse, 1);
         chk("R2 state", state, 1);
         chk("R2 single/four", {single, four}, {s, f});
         chk("R2 cleared", {mask, nested, aeoi, rs, sm, poll, rot}, 0);
         wr(1'b1, 8'hB7);
         chk("R3 base", base, 5'h16);
         chk("R6 mask kept in setup", mask, 0);
         pvalid = 1'b0; #1;
         chk("R11 spurious vector", vector, 8'hB7);
         pline = 3'd2; pvalid = 1'b1; #1;
         chk("R11 vector", vector, 8'hB2);
         pvalid = 1'b0;
         exp_st = s ? (f ? 2'd3 : 2'd0) : 2'd2;
         chk("R3 next state", state, exp_st);
         if (state == 2'd2) begin
            wr(1'b1, 8'h04);
            chk("R4 next state", state, f ? 2'd3 : 2'd0);
            chk("R6 mask kept in state 2", mask, 0);
         end
         if (state == 2'd3) begin
            wr(1'b1, {3'b000, s, 2'b00, ~s, 1'b0});
            chk("R5 state", state, 0);
            chk("R5 nested/aeoi", {nested, aeoi}, {s, ~s});
            chk("R6 mask kept in state 3", mask, 0);
         end
         wr(1'b1, 8'h3C);
         chk("R6 mask after setup", mask, 8'h3C);
      end

      // R7 / R10 all control encodings
      exp_rs = rs; exp_sm = sm;
      for (int i = 0; i < 64; i++) begin
         logic [7:0] d;
         logic [5:0] iv;
         iv = 6'(i);
         d = {iv[5], iv[4], iv[3], 1'b0, 1'b1, iv[2], iv[1], iv[0]};
         wr(1'b0, d);
         if (d[1]) exp_rs = d[0];
         if (d[6]) exp_sm = d[5];
         chk("R7 read select", rs, exp_rs);
         chk("R7 special mask", sm, exp_sm);
         chk("R7 poll armed", poll, d[2]);
         if (poll) begin
            pvalid = iv[5]; pline = iv[5:3] ^ 3'(i);
            rd(iv[0]);
            chk("R10 poll data", s_rd, pvalid ? {5'b0, pline} : 8'd7);
            chk("R10 poll clear", s_clr, pvalid ? (8'd1 << pline) : 8'd0);
            chk("R10 disarm", poll, 0);
            pvalid = 1'b0;
         end
      end

      // R9 read multiplexer
      wr(1'b1, 8'h96);
      for (int k = 0; k < 4; k++) begin
         pend = 8'h5A ^ 8'(k * 37); insvc = 8'hC3 + 8'(k * 11);
         wr(1'b0, 8'h0A);
         rd(1'b0);
         chk("R9 pending read", s_rd, pend);
         wr(1'b0, 8'h0B);
         rd(1'b0);
         chk("R9 in-service read", s_rd, insvc);
         rd(1'b1);
         chk("R9 mask read", s_rd, 8'h96);
         chk("R10 no clear on plain read", s_clr, 0);
      end

      // R8 command words
      exp_rot = rot;
      for (int o = 0; o < 8; o++) begin
         for (int l = 0; l < 8; l++) begin
            wr(1'b0, {3'(o), 2'b00, 3'(l)});
            if (o == 0) exp_rot = 1'b0;
            if (o == 4) exp_rot = 1'b1;
            chk("R8 strobe", {s_stb, s_pulse}, 2'b10);
            chk("R8 opcode/line", {s_op, s_lvl}, {3'(o), 3'(l)});
            chk("R8 rotate flag", rot, exp_rot);
         end
      end
      chk("R6 mask after commands", mask, 8'h96);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule